// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide one-time-programmable memory. It is meant to sit in front of a programming sequencer as a target that reports what the sequencer did. Every cell starts erased, with all bits at one. A program operation can only clear bits. Three active-low controls pick the mode: a chip select, an output gate and a program strobe. Two flags qualify them. One says the programming supply is raised. The other says the high-voltage identification condition is present on the address line that would carry it.

The block decodes these inputs every clock. It then returns a registered data byte, a separate data-valid flag that stands in for a driven (not tri-stated) bus, and a mode code. Identification mode returns fixed odd-parity bytes for the manufacturer and the device, or a continuation byte. The block also keeps a saturating count of program pulses for each address and shows it for the addressed location. A sequencer bench can use that count to confirm how many pulses each byte received.

All outputs change one clock after the inputs that cause them. A program event writes at the same clock edge, so a verify issued on the next cycle already sees the new byte.

Top module: `otp_byte_mem`

## Requirements
- R1: While rst is high, and on the first cycle after it falls, dout_en is 0, dout is 0x00 and mode is 0 (standby).
- R2: Any location that has never been programmed reads 0xFF.
- R3: A program event stores the old byte ANDed with din, so bits can only go from one to zero. Programming 0xFF leaves a byte unchanged.
- R4: Program inhibit: with vpp_hi set, pgm_n low and ce_n high, nothing is written. mode is 5 and dout_en is 0.
- R5: Program verify: with vpp_hi set, ce_n and oe_n low and pgm_n high, the stored byte appears on dout with dout_en 1. mode is 4.
- R6: Read: with vpp_hi clear, id_hv clear and ce_n and oe_n low, dout is the stored byte, dout_en is 1 and mode is 1.
- R7: ce_n high gives standby (mode 0, dout_en 0) whatever oe_n is. With ce_n low and oe_n high (and not program), the outputs are released (mode 2, dout_en 0).
- R8: Identification: with id_hv set, vpp_hi clear and ce_n and oe_n low, the mode is 6. With addr[1]=1, addr[0]=0 selects 0x1C and addr[0]=1 selects 0x01.
- R9: In identification mode with addr[1]=0, dout is 0x7F for either value of addr[0].
- R10: Every identification byte has odd parity, with bit 7 as the parity bit.
- R11: pulse_cnt shows the number of program events at the addressed location, counted before the current cycle's write. It saturates at 2**CNT_W-1.
- R12: Program mode (mode 3, write enabled) needs vpp_hi set, oe_n high and ce_n and pgm_n low. The same controls without vpp_hi write nothing and give mode 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | High-voltage identification condition present |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Registered data byte, 0x00 when not driven |
| dout_en | output | 1 | Data bus driven (0 stands for high impedance) |
| mode | output | 3 | Decoded mode: 0 standby, 1 read, 2 output off, 3 program, 4 verify, 5 inhibit, 6 identify |
| pulse_cnt | output | CNT_W | Saturating program-pulse count at the addressed location |

## Verification
The hardest case to reach from the ports is saturation of the per-address pulse counter. It needs more program pulses at one address than the counter can hold, with no stray write to that address in between. The stimulus programs 0xFF at one location 33 times; this data leaves the byte unchanged, so only the count moves. It then reads the count through verify cycles. The AND-only write rule is reached with successive patterns at one address, where each later byte sets bits the array must refuse.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    M_STANDBY = 3'd0,
    M_READ    = 3'd1,
    M_OFF     = 3'd2,
    M_PROG    = 3'd3,
    M_VERIFY  = 3'd4,
    M_INHIBIT = 3'd5,
    M_IDENT   = 3'd6
  } otp_mode_e;

  localparam logic [7:0] MAKER_BYTE = 8'h1C;
  localparam logic [7:0] PART_BYTE  = 8'h01;
  localparam logic [7:0] CONT_BYTE  = 8'h7F;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      pgm_n,
  input  logic      vpp_hi,
  input  logic      id_hv,
  output otp_mode_e mode
);

  always_comb begin
    if (vpp_hi) begin
      if (!ce_n && !pgm_n && oe_n)      mode = M_PROG;
      else if (ce_n && !pgm_n)          mode = M_INHIBIT;
      else if (!ce_n && !oe_n && pgm_n) mode = M_VERIFY;
      else if (ce_n)                    mode = M_STANDBY;
      else                              mode = M_OFF;
    end else begin
      if (ce_n)       mode = M_STANDBY;
      else if (oe_n)  mode = M_OFF;
      else if (id_hv) mode = M_IDENT;
      else            mode = M_READ;
    end
  end

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
  import otp_pkg::*;
(
  input  logic [1:0] sel,
  output logic [7:0] code
);

  always_comb begin
    if (!sel[1])     code = CONT_BYTE;
    else if (sel[0]) code = PART_BYTE;
    else             code = MAKER_BYTE;
  end

  always_comb begin
    assert_id_odd_R10: assert (^code == 1'b1);
  end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [CNT_W-1:0]  cnt
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [7:0]       cells  [DEPTH];
  logic [CNT_W-1:0] pulses [DEPTH];
  logic [7:0]       old_word;
  logic [CNT_W-1:0] old_cnt;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      cells[i]  = 8'hFF;
      pulses[i] = '0;
    end
  end

  assign old_word = cells[addr];
  assign old_cnt  = pulses[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[addr] <= old_word & wdata;
      if (old_cnt != CNT_TOP) pulses[addr] <= old_cnt + 1'b1;
    end
    rdata <= old_word;
    cnt   <= old_cnt;
  end

  assert_clear_only_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((cells[$past(addr)] & ~$past(old_word)) == 8'h00));

  assert_cnt_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pulses[$past(addr)] != '0));

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic [2:0]        mode,
  output logic [CNT_W-1:0]  pulse_cnt
);

  otp_mode_e  nxt_mode, mode_q;
  logic       en_q;
  logic [7:0] id_code, id_q, cell_q;

  otp_mode_decode u_dec (
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .pgm_n (pgm_n),
    .vpp_hi(vpp_hi),
    .id_hv (id_hv),
    .mode  (nxt_mode)
  );

  otp_id_rom u_id (
    .sel (addr[1:0]),
    .code(id_code)
  );

  otp_cell_array #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_arr (
    .clk  (clk),
    .rst  (rst),
    .wr_en(nxt_mode == M_PROG),
    .addr (addr),
    .wdata(din),
    .rdata(cell_q),
    .cnt  (pulse_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_STANDBY;
      en_q   <= 1'b0;
      id_q   <= 8'h00;
    end else begin
      mode_q <= nxt_mode;
      en_q   <= (nxt_mode == M_READ) || (nxt_mode == M_VERIFY) ||
                (nxt_mode == M_IDENT);
      id_q   <= id_code;
    end
  end

  assign mode    = mode_q;
  assign dout_en = en_q;
  assign dout    = !en_q ? 8'h00 : (mode_q == M_IDENT) ? id_q : cell_q;

  assert_standby_released_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_STANDBY) |-> !dout_en);

  assert_id_parity_R10: assert property (@(posedge clk) disable iff (rst)
    (dout_en && mode_q == M_IDENT) |-> (^dout == 1'b1));

  assert_prog_needs_vpp_R12: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PROG) |-> ($past(vpp_hi) && !dout_en));

endmodule

// File: tb/tb_otp_byte_mem.sv
`timescale 1ns/100ps
module tb_otp_byte_mem;

  localparam int AW = 10;
  localparam int CW = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_en;
  logic [2:0] mode;
  logic [CW-1:0] pulse_cnt;

  always #2.5 clk = ~clk;

  otp_byte_mem #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .mode(mode), .pulse_cnt(pulse_cnt)
  );

  typedef struct {
    logic       en;
    logic [7:0] data;
    logic [2:0] md;
    int         cnt;
    string      tag;
  } exp_t;

  exp_t sb[$];
  logic [7:0] ref_mem [int];
  int ref_cnt [int];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic logic [7:0] stored(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'hFF;
  endfunction

  function automatic int pulses(int a);
    return ref_cnt.exists(a) ? ref_cnt[a] : 0;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic c, input logic o, input logic p,
                       input logic v, input logic h, input int a,
                       input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = h;
    addr = a[AW-1:0]; din = d;
    // mode from the R4/R5/R7/R8/R12 rules
    if (v) begin
      if (!c && !p && o)      e.md = 3'd3;
      else if (c && !p)       e.md = 3'd5;
      else if (!c && !o && p) e.md = 3'd4;
      else if (c)             e.md = 3'd0;
      else                    e.md = 3'd2;
    end else begin
      if (c)      e.md = 3'd0;
      else if (o) e.md = 3'd2;
      else if (h) e.md = 3'd6;
      else        e.md = 3'd1;
    end
    e.en = (e.md == 3'd1) || (e.md == 3'd4) || (e.md == 3'd6);
    if (e.md == 3'd6)
      e.data = !a[1] ? 8'h7F : (a[0] ? 8'h01 : 8'h1C);
    else
      e.data = stored(a);
    e.cnt = pulses(a);
    e.tag = tag;
    sb.push_back(e);
    if (e.md == 3'd3) begin
      ref_mem[a] = stored(a) & d;
      if (pulses(a) < CMAX) ref_cnt[a] = pulses(a) + 1;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check(mode == e.md, e.tag, "mode", mode, e.md);
        check(dout_en == e.en, e.tag, "dout_en", dout_en, e.en);
        if (e.en) check(dout == e.data, e.tag, "dout", dout, e.data);
        else      check(dout == 8'h00, e.tag, "dout idle", dout, 0);
        check(int'(pulse_cnt) == e.cnt, e.tag, "pulse_cnt", pulse_cnt, e.cnt);
        if (e.md == 3'd6) check(^dout == 1'b1, "R10", "parity", dout, e.data);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dout_en == 1'b0, "R1", "dout_en in reset", dout_en, 0);
    check(dout == 8'h00, "R1", "dout in reset", dout, 0);
    check(mode == 3'd0, "R1", "mode in reset", mode, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(dout_en == 1'b0 && mode == 3'd0, "R1", "first cycle after reset",
          {mode, dout_en}, 0);

    // R2: erased reads
    apply(0, 0, 1, 0, 0, 12, 8'h00, "R2");
    apply(0, 0, 1, 0, 0, 1023, 8'h00, "R2");
    // R3/R5: program then verify, AND rule
    apply(0, 1, 0, 1, 0, 5, 8'hA5, "R3");
    apply(0, 0, 1, 1, 0, 5, 8'h00, "R5");
    apply(0, 1, 0, 1, 0, 5, 8'hF0, "R3");
    apply(0, 0, 1, 1, 0, 5, 8'h00, "R3");
    apply(0, 1, 0, 1, 0, 5, 8'hFF, "R3");
    apply(0, 0, 1, 1, 0, 5, 8'h00, "R3");
    // R6: normal read
    apply(0, 0, 1, 0, 0, 5, 8'h00, "R6");
    // R4: inhibit leaves byte unchanged
    apply(1, 1, 0, 1, 0, 7, 8'h00, "R4");
    apply(1, 0, 0, 1, 0, 7, 8'h11, "R4");
    apply(0, 0, 1, 1, 0, 7, 8'h00, "R4");
    // R12: program controls without vpp
    apply(0, 1, 0, 0, 0, 8, 8'h00, "R12");
    apply(0, 0, 1, 0, 0, 8, 8'h00, "R12");
    // R7: standby and output off
    apply(1, 0, 1, 0, 0, 5, 8'h00, "R7");
    apply(1, 1, 1, 0, 0, 5, 8'h00, "R7");
    apply(0, 1, 1, 0, 0, 5, 8'h00, "R7");
    apply(0, 1, 1, 1, 0, 5, 8'h00, "R7");
    // R8/R9/R10: identification
    apply(0, 0, 1, 0, 1, 2, 8'h00, "R8");
    apply(0, 0, 1, 0, 1, 3, 8'h00, "R8");
    apply(0, 0, 1, 0, 1, 0, 8'h00, "R9");
    apply(0, 0, 1, 0, 1, 1, 8'h00, "R9");
    apply(1, 0, 1, 0, 1, 2, 8'h00, "R7");
    // R11: pulse counting and saturation
    for (int i = 0; i < 33; i++) apply(0, 1, 0, 1, 0, 9, 8'hFF, "R11");
    apply(0, 0, 1, 1, 0, 9, 8'h00, "R11");
    apply(0, 0, 1, 1, 0, 5, 8'h00, "R11");
    apply(0, 1, 0, 1, 0, 300, 8'h3C, "R11");
    apply(0, 0, 1, 0, 0, 300, 8'h00, "R11");
    // idle and drain
    apply(1, 1, 1, 0, 0, 0, 8'h00, "R7");
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule